// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Ready-to-Send Handshake

This block receives asynchronous serial frames on a single input line and hands each completed byte to a one-entry receive buffer. The bit clock is produced locally: the peripheral clock, taken either directly or after a fixed divide-by-8, is divided by an 8-bit reload value plus one. The result is a 16x oversampling tick. A falling edge on the line starts a frame. Every bit is resolved by a majority vote over three oversamples at the middle of the bit.

When a frame completes, the received byte and its error flags move into the buffer, and a receive-complete flag and an interrupt-request flag are set. The host takes the byte with a read strobe. It clears the interrupt request separately, either with an acknowledge strobe or with a software clear strobe. A ready-to-send output, active low, tells the far end when another frame may be sent. It is high while a frame is arriving and while the buffer holds unread data, and low once the receiver is enabled, idle and empty.

Top module: `uart_rx_rts`

## Requirements
- R1: One bit lasts 16*(n+1) periods of the count source, where n is `reload_i`. The count source is `clk_i` when `src_div8_i`=0 and `clk_i`/8 when `src_div8_i`=1.
- R2: A falling edge on `rxd_i` while the receiver is idle and enabled starts a frame. If the majority of oversamples 7, 8 and 9 of the start bit is high, the receiver returns to idle and stores nothing.
- R3: A frame carries 8 data bits, least significant first, each bit taken as the majority of oversamples 7, 8 and 9. At the middle of the last stop bit the byte is written to `rx_data_o` and `rx_done_o` is set.
- R4: With `parity_en_i`=1, one parity bit follows D7. Parity is even: the count of ones in the data and parity bits together is even. A mismatch sets `pe_o`, and `pe_o` always describes the most recently stored frame.
- R5: With `two_stop_i`=1 two stop bits are expected, otherwise one. Any stop bit sampled low sets `fe_o` for the stored frame. The byte is still stored.
- R6: `irq_o` is set with each store. It is cleared by `irq_ack_i` or by `irq_clr_i`, and neither clear affects `rx_done_o`. If a store and a clear fall in the same cycle, the store wins.
- R7: A one-cycle `buf_rd_i` clears `rx_done_o` and `ore_o`. `rx_data_o` keeps its value.
- R8: If a frame completes while `rx_done_o`=1 and no read occurs in that cycle, `ore_o` is set. `rx_data_o`, `fe_o` and `pe_o` keep the old frame's values, and `rx_done_o` stays 1.
- R9: When `flow_en_i`=1 and `rts_sel_i`=1, `rts_o` is 0 exactly when `rx_en_i`=1, the receiver is idle and `rx_done_o`=0; otherwise it is 1. If either control is 0, `rts_o` is held at 0.
- R10: Clearing `rx_en_i` abandons any frame in progress without a store and returns the receiver to idle. The buffer and its flags are unaffected.
- R11: After reset `rx_data_o` is 0 and `rx_done_o`, `irq_o`, `fe_o`, `pe_o` and `ore_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Peripheral clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_en_i | input | 1 | Receive enable |
| src_div8_i | input | 1 | Count source select: 0 undivided clock, 1 clock/8 |
| reload_i | input | 8 | Baud reload value n |
| parity_en_i | input | 1 | Expect an even parity bit |
| two_stop_i | input | 1 | Expect two stop bits |
| flow_en_i | input | 1 | Flow-control enable |
| rts_sel_i | input | 1 | Select the ready-to-send function |
| rxd_i | input | 1 | Serial receive line |
| buf_rd_i | input | 1 | Buffer read strobe |
| irq_ack_i | input | 1 | Interrupt acknowledge strobe |
| irq_clr_i | input | 1 | Software clear of the interrupt request |
| rx_data_o | output | 8 | Receive buffer contents |
| rx_done_o | output | 1 | Receive complete, buffer holds unread data |
| irq_o | output | 1 | Interrupt request flag |
| fe_o | output | 1 | Framing error of the stored frame |
| pe_o | output | 1 | Parity error of the stored frame |
| ore_o | output | 1 | Overrun flag |
| rts_o | output | 1 | Ready to send, active low |

## Verification
The hardest situations to reach from the ports are a start bit that dies before its mid-bit vote and a receive enable dropped part-way through a frame. Both depend on where the line sits relative to the oversampling tick, which is restarted at each falling edge. The bench drives the line with bit lengths computed from the rate formula. It forces the false start with a low pulse only four ticks long. It cuts the enable one and a half bits into a frame and then checks that no byte appears and that the handshake returns to ready. Overrun is reached by sending two frames without a read between them.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  localparam int DATA_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } rx_state_e;

  typedef struct packed {
    logic [DATA_W-1:0] data;
    logic              fe;
    logic              pe;
  } rx_frame_t;

  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction
endpackage

// File: rtl/uart_rx_baud.sv
module uart_rx_baud #(
  parameter int RELOAD_W = 8,
  parameter int PRE_DIV  = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                restart_i,
  input  logic                src_div_i,
  input  logic [RELOAD_W-1:0] reload_i,
  output logic                tick_o
);
  localparam int PW = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;
  localparam logic [PW-1:0] PRE_LAST = PW'(PRE_DIV - 1);

  logic [PW-1:0]       pre_q;
  logic [RELOAD_W-1:0] cnt_q;
  logic                src_en;

  assign src_en = src_div_i ? (pre_q == PRE_LAST) : 1'b1;
  assign tick_o = src_en && (cnt_q == '0) && !restart_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else if (restart_i) begin
      // phase-align the divider to the detected edge
      pre_q <= '0;
      cnt_q <= reload_i;
    end else begin
      pre_q <= (pre_q == PRE_LAST) ? '0 : pre_q + 1'b1;
      if (src_en) begin
        cnt_q <= (cnt_q == '0) ? reload_i : cnt_q - 1'b1;
      end
    end
  end
endmodule

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rxd_i,
  output logic rx_o,
  output logic fall_o
);
  logic [STAGES-1:0] sh_q;
  logic              prev_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sh_q[g] <= 1'b1;
        else if (g == 0) sh_q[g] <= rxd_i;
        else sh_q[g] <= sh_q[(g > 0) ? g - 1 : 0];
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b1;
    else prev_q <= sh_q[STAGES-1];
  end

  assign rx_o   = sh_q[STAGES-1];
  assign fall_o = prev_q & ~sh_q[STAGES-1];
endmodule

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
  import uart_rx_pkg::*;
#(
  parameter int OS_W = 4
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      en_i,
  input  logic      rx_i,
  input  logic      fall_i,
  input  logic      tick_i,
  input  logic      par_en_i,
  input  logic      two_stop_i,
  output logic      restart_o,
  output logic      idle_o,
  output logic      done_o,
  output rx_frame_t frame_o
);
  localparam int BW = $clog2(DATA_W);
  localparam logic [OS_W-1:0] OS_S0   = OS_W'(7);
  localparam logic [OS_W-1:0] OS_S1   = OS_W'(8);
  localparam logic [OS_W-1:0] OS_VOTE = OS_W'(9);
  localparam logic [OS_W-1:0] OS_LAST = '1;
  localparam logic [BW-1:0]   BIT_LAST = BW'(DATA_W - 1);

  rx_state_e         st_q;
  logic [OS_W-1:0]   os_q;
  logic [BW-1:0]     bit_q;
  logic              stop_q;
  logic              s0_q, s1_q;
  logic [DATA_W-1:0] sh_q;
  logic              par_q, pe_q, fe_q;
  logic              vote, at_vote, at_end, last_stop;

  assign vote      = maj3(s0_q, s1_q, rx_i);
  assign at_vote   = tick_i && (os_q == OS_VOTE);
  assign at_end    = tick_i && (os_q == OS_LAST);
  assign last_stop = (stop_q == two_stop_i);
  assign restart_o = (st_q == ST_IDLE) && en_i && fall_i;
  assign idle_o    = (st_q == ST_IDLE);
  assign done_o    = en_i && (st_q == ST_STOP) && at_vote && last_stop;
  assign frame_o   = '{data: sh_q, fe: fe_q | ~vote, pe: pe_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      os_q   <= '0;
      bit_q  <= '0;
      stop_q <= 1'b0;
      s0_q   <= 1'b1;
      s1_q   <= 1'b1;
      sh_q   <= '0;
      par_q  <= 1'b0;
      pe_q   <= 1'b0;
      fe_q   <= 1'b0;
    end else if (!en_i) begin
      st_q <= ST_IDLE;
    end else if (st_q == ST_IDLE) begin
      if (fall_i) begin
        st_q   <= ST_START;
        os_q   <= '0;
        bit_q  <= '0;
        stop_q <= 1'b0;
        par_q  <= 1'b0;
        pe_q   <= 1'b0;
        fe_q   <= 1'b0;
      end
    end else if (tick_i) begin
      os_q <= os_q + 1'b1;
      if (os_q == OS_S0) s0_q <= rx_i;
      if (os_q == OS_S1) s1_q <= rx_i;
      unique case (st_q)
        ST_START: begin
          if (at_vote && vote) st_q <= ST_IDLE;  // false start
          else if (at_end) st_q <= ST_DATA;
        end
        ST_DATA: begin
          if (at_vote) begin
            sh_q  <= {vote, sh_q[DATA_W-1:1]};
            par_q <= par_q ^ vote;
          end
          if (at_end) begin
            if (bit_q == BIT_LAST) st_q <= par_en_i ? ST_PAR : ST_STOP;
            else bit_q <= bit_q + 1'b1;
          end
        end
        ST_PAR: begin
          if (at_vote) pe_q <= par_q ^ vote;
          if (at_end) st_q <= ST_STOP;
        end
        ST_STOP: begin
          if (at_vote) begin
            fe_q <= fe_q | ~vote;
            if (last_stop) st_q <= ST_IDLE;
          end
          if (at_end) stop_q <= 1'b1;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/uart_rx_hold.sv
module uart_rx_hold
  import uart_rx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              store_i,
  input  rx_frame_t         frame_i,
  input  logic              rd_i,
  input  logic              ack_i,
  input  logic              clr_i,
  input  logic              en_i,
  input  logic              idle_i,
  input  logic              flow_en_i,
  input  logic              rts_sel_i,
  output logic [DATA_W-1:0] data_o,
  output logic              done_o,
  output logic              irq_o,
  output logic              fe_o,
  output logic              pe_o,
  output logic              ore_o,
  output logic              rts_o
);
  logic [DATA_W-1:0] data_q;
  logic done_q, irq_q, fe_q, pe_q, ore_q, full_blk;

  assign full_blk = done_q && !rd_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      done_q <= 1'b0;
      irq_q  <= 1'b0;
      fe_q   <= 1'b0;
      pe_q   <= 1'b0;
      ore_q  <= 1'b0;
    end else begin
      if (store_i && !full_blk) begin
        data_q <= frame_i.data;
        fe_q   <= frame_i.fe;
        pe_q   <= frame_i.pe;
        done_q <= 1'b1;
        irq_q  <= 1'b1;
      end else begin
        if (rd_i) done_q <= 1'b0;
        if (ack_i || clr_i) irq_q <= 1'b0;
      end
      if (store_i && full_blk) ore_q <= 1'b1;
      else if (rd_i) ore_q <= 1'b0;
    end
  end

  assign data_o = data_q;
  assign done_o = done_q;
  assign irq_o  = irq_q;
  assign fe_o   = fe_q;
  assign pe_o   = pe_q;
  assign ore_o  = ore_q;
  assign rts_o  = (flow_en_i && rts_sel_i) ? !(en_i && idle_i && !done_q) : 1'b0;
endmodule

// File: rtl/uart_rx_rts.sv
module uart_rx_rts
  import uart_rx_pkg::*;
#(
  parameter int RELOAD_W    = 8,
  parameter int PRE_DIV     = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                rx_en_i,
  input  logic                src_div8_i,
  input  logic [RELOAD_W-1:0] reload_i,
  input  logic                parity_en_i,
  input  logic                two_stop_i,
  input  logic                flow_en_i,
  input  logic                rts_sel_i,
  input  logic                rxd_i,
  input  logic                buf_rd_i,
  input  logic                irq_ack_i,
  input  logic                irq_clr_i,
  output logic [DATA_W-1:0]   rx_data_o,
  output logic                rx_done_o,
  output logic                irq_o,
  output logic                fe_o,
  output logic                pe_o,
  output logic                ore_o,
  output logic                rts_o
);
  logic      rx_s, rx_fall, tick, restart, rx_idle, frame_store;
  rx_frame_t frame;

  uart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i), .rst_ni(rst_ni), .rxd_i(rxd_i),
    .rx_o  (rx_s),  .fall_o(rx_fall)
  );

  uart_rx_baud #(.RELOAD_W(RELOAD_W), .PRE_DIV(PRE_DIV)) u_baud (
    .clk_i    (clk_i),      .rst_ni  (rst_ni),  .restart_i(restart),
    .src_div_i(src_div8_i), .reload_i(reload_i), .tick_o  (tick)
  );

  uart_rx_frame u_frame (
    .clk_i     (clk_i),       .rst_ni    (rst_ni),     .en_i   (rx_en_i),
    .rx_i      (rx_s),        .fall_i    (rx_fall),    .tick_i (tick),
    .par_en_i  (parity_en_i), .two_stop_i(two_stop_i), .restart_o(restart),
    .idle_o    (rx_idle),     .done_o    (frame_store), .frame_o(frame)
  );

  uart_rx_hold u_hold (
    .clk_i    (clk_i),     .rst_ni   (rst_ni),    .store_i(frame_store),
    .frame_i  (frame),     .rd_i     (buf_rd_i),  .ack_i  (irq_ack_i),
    .clr_i    (irq_clr_i), .en_i     (rx_en_i),   .idle_i (rx_idle),
    .flow_en_i(flow_en_i), .rts_sel_i(rts_sel_i), .data_o (rx_data_o),
    .done_o   (rx_done_o), .irq_o    (irq_o),     .fe_o   (fe_o),
    .pe_o     (pe_o),      .ore_o    (ore_o),     .rts_o  (rts_o)
  );
endmodule

// File: rtl/uart_rx_rts_chk.sv
module uart_rx_rts_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       rx_en_i,
  input logic       flow_en_i,
  input logic       rts_sel_i,
  input logic       buf_rd_i,
  input logic       irq_ack_i,
  input logic       irq_clr_i,
  input logic [7:0] rx_data_o,
  input logic       rx_done_o,
  input logic       irq_o,
  input logic       ore_o,
  input logic       rts_o,
  input logic       frame_store,
  input logic       rx_idle
);
  p_rts_inactive_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(flow_en_i && rts_sel_i) |-> !rts_o);

  p_rts_busy_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flow_en_i && rts_sel_i && !rx_idle) |-> rts_o);

  p_irq_on_store_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rx_done_o) |-> irq_o);

  p_irq_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((irq_ack_i || irq_clr_i) && !frame_store) |=> !irq_o);

  p_read_clears_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (buf_rd_i && !frame_store) |=> (!rx_done_o && !ore_o));

  p_overrun_keeps_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_done_o && !buf_rd_i && frame_store) |=> ($stable(rx_data_o) && ore_o && rx_done_o));

  p_abort_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_en_i |=> rx_idle);
endmodule

bind uart_rx_rts uart_rx_rts_chk chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .rx_en_i    (rx_en_i),
  .flow_en_i  (flow_en_i),
  .rts_sel_i  (rts_sel_i),
  .buf_rd_i   (buf_rd_i),
  .irq_ack_i  (irq_ack_i),
  .irq_clr_i  (irq_clr_i),
  .rx_data_o  (rx_data_o),
  .rx_done_o  (rx_done_o),
  .irq_o      (irq_o),
  .ore_o      (ore_o),
  .rts_o      (rts_o),
  .frame_store(frame_store),
  .rx_idle    (rx_idle)
);

// File: tb/uart_rx_rts_tb_top.sv
module uart_rx_rts_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_en = 1'b0, src_div8 = 1'b0, par_en = 1'b0, two_stop = 1'b0;
  logic       flow_en = 1'b1, rts_sel = 1'b1, rxd = 1'b1;
  logic       buf_rd = 1'b0, irq_ack = 1'b0, irq_clr = 1'b0;
  logic [7:0] reload = 8'd1;
  logic [7:0] rx_data;
  logic       rx_done, irq, fe, pe, ore, rts;

  int n_cmp = 0;
  int n_bad = 0;
  bit done_flag = 0;

  always #2 clk = ~clk;

  uart_rx_rts dut_i (
    .clk_i(clk), .rst_ni(rst_n), .rx_en_i(rx_en), .src_div8_i(src_div8),
    .reload_i(reload), .parity_en_i(par_en), .two_stop_i(two_stop),
    .flow_en_i(flow_en), .rts_sel_i(rts_sel), .rxd_i(rxd), .buf_rd_i(buf_rd),
    .irq_ack_i(irq_ack), .irq_clr_i(irq_clr), .rx_data_o(rx_data),
    .rx_done_o(rx_done), .irq_o(irq), .fe_o(fe), .pe_o(pe), .ore_o(ore), .rts_o(rts)
  );

  task automatic wclk(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int bit_clks();
    return 16 * (int'(reload) + 1) * (src_div8 ? 8 : 1);
  endfunction

  function automatic logic even_par(input logic [7:0] d);
    return ^d;
  endfunction

  task automatic send_frame(input logic [7:0] d, input bit bad_par, input bit stop_low);
    int bt = bit_clks();
    rxd = 1'b1; wclk(bt);
    rxd = 1'b0; wclk(bt);
    for (int i = 0; i < 8; i++) begin
      rxd = d[i]; wclk(bt);
    end
    if (par_en) begin
      rxd = even_par(d) ^ bad_par; wclk(bt);
    end
    rxd = ~stop_low; wclk(bt);
    if (two_stop) begin
      rxd = ~stop_low; wclk(bt);
    end
    rxd = 1'b1;
    wclk(4);
  endtask

  task automatic pulse_rd();
    buf_rd = 1'b1; wclk(1); buf_rd = 1'b0; wclk(1);
  endtask

  initial begin
    #(4 * 190000);
    n_bad++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    if (!done_flag) begin
      done_flag = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    end
    $finish;
  end

  initial begin
    logic [7:0] d, a;
    bit bp, sl;
    void'($urandom(32'd4711));
    wclk(3);
    rst_n = 1'b1;
    wclk(2);
    // R11 reset state
    chk("R11 data", rx_data, 0);
    chk("R11 done", rx_done, 0);
    chk("R11 irq", irq, 0);
    chk("R11 flags", {fe, pe, ore}, 0);
    chk("R9 rts while disabled", rts, 1);
    rx_en = 1'b1; wclk(2);
    chk("R9 rts ready", rts, 0);

    // R1 slow rate, undivided source
    reload = 8'd103; src_div8 = 1'b0;
    send_frame(8'hA5, 0, 0);
    chk("R1 n=103 data", rx_data, 8'hA5);
    chk("R3 done", rx_done, 1);
    chk("R9 rts full", rts, 1);
    pulse_rd();
    chk("R7 read clears", rx_done, 0);
    chk("R7 data kept", rx_data, 8'hA5);

    // R1 divided source
    reload = 8'd3; src_div8 = 1'b1;
    send_frame(8'h3C, 0, 0);
    chk("R1 div8 data", rx_data, 8'h3C);
    pulse_rd();

    // random frames
    for (int k = 0; k < 16; k++) begin
      reload   = 8'($urandom_range(0, 3));
      src_div8 = (reload < 2) ? 1'($urandom_range(0, 1)) : 1'b0;
      par_en   = 1'($urandom_range(0, 1));
      two_stop = 1'($urandom_range(0, 1));
      d  = 8'($urandom);
      bp = par_en && ($urandom_range(0, 3) == 0);
      sl = ($urandom_range(0, 4) == 0);
      send_frame(d, bp, sl);
      chk("R3 data", rx_data, d);
      chk("R3 done", rx_done, 1);
      chk("R6 irq set", irq, 1);
      chk("R4 parity flag", pe, bp);
      chk("R5 stop flag", fe, sl);
      pulse_rd();
      irq_ack = 1'b1; wclk(1); irq_ack = 1'b0; wclk(1);
      chk("R7 cleared", rx_done, 0);
    end

    // R4 / R5 directed
    reload = 8'd1; src_div8 = 1'b0; par_en = 1'b1; two_stop = 1'b1;
    send_frame(8'h81, 1, 0);
    chk("R4 bad parity", pe, 1);
    chk("R5 good stops", fe, 0);
    pulse_rd();
    send_frame(8'h7E, 0, 1);
    chk("R4 good parity", pe, 0);
    chk("R5 low stops", fe, 1);
    chk("R5 data still stored", rx_data, 8'h7E);

    // R6 software clear leaves done alone
    irq_clr = 1'b1; wclk(1); irq_clr = 1'b0; wclk(1);
    chk("R6 clr irq", irq, 0);
    chk("R6 done untouched", rx_done, 1);
    pulse_rd();

    // R8 overrun
    par_en = 1'b0; two_stop = 1'b0;
    a = 8'h5A;
    send_frame(a, 0, 0);
    send_frame(8'hC3, 0, 1);
    chk("R8 ore", ore, 1);
    chk("R8 data kept", rx_data, a);
    chk("R8 fe kept", fe, 0);
    chk("R8 done", rx_done, 1);
    pulse_rd();
    chk("R7 ore cleared", ore, 0);
    irq_ack = 1'b1; wclk(1); irq_ack = 1'b0; wclk(1);
    chk("R6 ack irq", irq, 0);

    // R2 false start: low for 4 ticks only
    rxd = 1'b0; wclk(4 * 2);
    rxd = 1'b1; wclk(16 * 2 * 12);
    chk("R2 false start no store", rx_done, 0);
    chk("R2 back to ready", rts, 0);

    // R9 / R10 abort mid-frame
    rxd = 1'b0; wclk(32);
    rxd = 1'b1; wclk(16);
    chk("R9 rts busy", rts, 1);
    flow_en = 1'b0; wclk(1);
    chk("R9 rts off when disabled", rts, 0);
    flow_en = 1'b1;
    rx_en = 1'b0; wclk(2);
    chk("R10 rts after abort", rts, 1);
    rx_en = 1'b1; wclk(2);
    chk("R10 ready again", rts, 0);
    wclk(32 * 12);
    chk("R10 no store", rx_done, 0);
    send_frame(8'h96, 0, 0);
    chk("R10 works after abort", rx_data, 8'h96);

    if (!done_flag) begin
      done_flag = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    end
    $finish;
  end
endmodule